// File: doc/BRIEF.md
# Quadrature Carrier Oscillator and I/Q Modulator

This block generates a digital carrier from a 32-bit phase accumulator and uses it to upconvert a complex baseband stream. Each clock the accumulator advances by a tuning word. The top bits of the accumulated phase address a sine table that stores one quadrant. That table gives a sine sample and a cosine sample in the same cycle. A signed I sample and a signed Q sample are mixed with the two carriers and summed into one real output. The result is rounded and saturated to 12 bits.

Four tuning words are held in the block, and two select pins choose which one drives the accumulator. Software writes the words one byte at a time into a staging copy. An update strobe then moves all four staged words into the working copy at once, so a word that is only partly written never reaches the carrier. Switching between profiles keeps the phase continuous. An inversion input flips the sign of the Q term, which mirrors the output spectrum. A tone mode ignores the data and outputs the cosine carrier alone, for plain frequency synthesis.

Top module: `nco_qmod`

## Requirements
- R1: After a synchronous active-high reset, the accumulator, all staged words, all working words and `dout` are zero, and `dout` stays 0 while `i_in` and `q_in` are 0.
- R2: A write with `wr_en` high places `wr_byte` into bits [8k+7:8k] of the staged word of profile `wr_prof`, where k is `wr_lane`. A write alone leaves the carrier frequency unchanged.
- R3: A high `freq_update` on a clock edge copies all four staged words into the working words. A byte written on that same edge lands only in the staged copy, and the copy takes the staged contents from before that edge.
- R4: On every edge the accumulator adds the working word of the profile that `prof_sel` selects, modulo 2^32. A change of `prof_sel` does not reset the phase.
- R5: With p equal to accumulator bits [31:24], the sine sample is round(2047·sin(2π(p+0.5)/256)) and the cosine sample is the sine sample at (p+64) mod 256. Both are positive in the first quadrant.
- R6: With `spec_inv` at 0, y = I·C − Q·S, and the output is floor((y+1024)/2048).
- R7: With `spec_inv` at 1, y = I·C + Q·S, and the output is scaled and rounded as in R6.
- R8: Results above 2047 saturate to 2047, and results below −2048 saturate to −2048.
- R9: With `tone_mode` at 1, `dout` equals the cosine sample, and `i_in`, `q_in` and `spec_inv` have no effect.
- R10: Inputs sampled on edge t, together with the accumulator value held just before edge t, appear on `dout` after edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe into the staged tuning words |
| wr_prof | input | 2 | Profile addressed by the write |
| wr_lane | input | 2 | Byte position inside the 32-bit word |
| wr_byte | input | 8 | Byte to store |
| freq_update | input | 1 | Copies the staged words into the working words |
| prof_sel | input | 2 | Selects the working word that drives the accumulator |
| spec_inv | input | 1 | Inverts the sign of the Q term |
| tone_mode | input | 1 | Outputs the carrier alone and ignores the data |
| i_in | input | 12 | In-phase sample, two's complement |
| q_in | input | 12 | Quadrature sample, two's complement |
| dout | output | 12 | Upconverted output, two's complement |

## Verification
Some properties are checked on every cycle. Without an update strobe and with a steady select, the working tuning word stays the same. Both carrier samples are positive when the phase lies in the first quadrant. The sum of their magnitudes never falls below the amplitude. Zero data with tone mode off always gives a zero output. Other behaviour shows up only in the bench scenarios, where outputs are compared against a cycle-accurate reference model. These include the exact table values, the order of staging and updating (including a write on the same edge as an update), continuous phase across random profile switching, both mixing signs, saturation at full-scale data, and the two-edge latency.

// File: rtl/nco_qmod_pkg.sv
package nco_qmod_pkg;
   // sign applied to the Q product before summation
   typedef enum logic {
      MIX_SUB = 1'b0,
      MIX_ADD = 1'b1
   } mix_sign_e;

   // control fields travelling with one I/Q sample
   typedef struct packed {
      logic      tone;
      mix_sign_e sign;
   } mix_ctl_t;
endpackage

// File: rtl/nco_profile_bank.sv
module nco_profile_bank #(
   parameter int ACC_W = 32,
   parameter int NPROF = 4,
   localparam int PSEL_W = $clog2(NPROF),
   localparam int LANES  = ACC_W / 8,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [PSEL_W-1:0] wr_prof,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [7:0]        wr_byte,
   input  logic              upd,
   input  logic [PSEL_W-1:0] sel,
   output logic [ACC_W-1:0]  ftw
);
   if (ACC_W % 8 != 0 || ACC_W < 16) begin : g_bad_acc
      $error("ACC_W must be a multiple of 8 and at least 16");
   end
   if (NPROF < 2 || (1 << PSEL_W) != NPROF) begin : g_bad_prof
      $error("NPROF must be a power of two of at least 2");
   end

   logic [ACC_W-1:0] act_vec [NPROF];

   for (genvar g = 0; g < NPROF; g++) begin : g_prof
      logic [ACC_W-1:0] stg;
      logic [ACC_W-1:0] act;
      always_ff @(posedge clk) begin
         if (rst) begin
            stg <= '0;
            act <= '0;
         end else begin
            if (wr_en && wr_prof == PSEL_W'(g))
               stg[{wr_lane, 3'b000} +: 8] <= wr_byte;
            if (upd)
               act <= stg;
         end
      end
      assign act_vec[g] = act;
   end

   assign ftw = act_vec[sel];

   // R2: byte writes stay hidden until an update strobe
   a_r2_staged_hidden: assert property (@(posedge clk) disable iff (rst)
      (!$past(upd) && $stable(sel)) |-> $stable(ftw));
endmodule

// File: rtl/nco_phase_lut.sv
module nco_phase_lut #(
   parameter int ACC_W = 32,
   parameter int LUT_W = 8,
   parameter int DW    = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ACC_W-1:0]     ftw,
   output logic signed [DW-1:0] sin_q,
   output logic signed [DW-1:0] cos_q
);
   localparam int  QW  = LUT_W - 2;
   localparam int  QN  = 1 << QW;
   localparam int  AMP = (1 << (DW - 1)) - 1;
   localparam real PI  = 3.14159265358979323846;

   if (LUT_W < 3 || LUT_W > ACC_W || LUT_W > 14) begin : g_bad_lut
      $error("LUT_W must lie in 3..14 and not exceed ACC_W");
   end
   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("DW must lie in 4..24");
   end

   // one quadrant, sampled half a step off the axes so the folding is exact
   logic [DW-2:0] qtab [QN];
   for (genvar k = 0; k < QN; k++) begin : g_q
      localparam int QV = $rtoi(AMP * $sin(PI * (real'(k) + 0.5) / (2.0 * QN)) + 0.5);
      assign qtab[k] = (DW-1)'(QV);
   end

   function automatic logic signed [DW-1:0] wave(input logic [LUT_W-1:0] ph);
      logic [QW-1:0] idx;
      logic [DW-2:0] mag;
      idx  = ph[LUT_W-2] ? ~ph[QW-1:0] : ph[QW-1:0];
      mag  = qtab[idx];
      wave = ph[LUT_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   endfunction

   logic [ACC_W-1:0] acc;
   logic [LUT_W-1:0] ph_s, ph_c;
   logic             live_q;

   assign ph_s = acc[ACC_W-1 -: LUT_W];
   assign ph_c = ph_s + LUT_W'(QN);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc    <= '0;
         sin_q  <= '0;
         cos_q  <= '0;
         live_q <= 1'b0;
      end else begin
         acc    <= acc + ftw;
         sin_q  <= wave(ph_s);
         cos_q  <= wave(ph_c);
         live_q <= 1'b1;
      end
   end

   // R5: first quadrant gives two positive samples
   a_r5_quad_sign: assert property (@(posedge clk) disable iff (rst || !live_q)
      ($past(acc[ACC_W-1 -: 2]) == 2'b00) |-> (sin_q > 0 && cos_q > 0));

   // R5: the pair never collapses below the amplitude
   a_r5_magnitude: assert property (@(posedge clk) disable iff (rst || !live_q)
      ((sin_q < 0 ? -int'(sin_q) : int'(sin_q)) +
       (cos_q < 0 ? -int'(cos_q) : int'(cos_q))) >= AMP - 2);
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
   import nco_qmod_pkg::*;
#(
   parameter int DW         = 12,
   parameter bit ROUND_HALF = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [DW-1:0] i_in,
   input  logic signed [DW-1:0] q_in,
   input  logic                 inv,
   input  logic                 tone,
   input  logic signed [DW-1:0] sin_in,
   input  logic signed [DW-1:0] cos_in,
   output logic signed [DW-1:0] dout
);
   localparam int PW    = 2 * DW;
   localparam int SW    = PW + 1;
   localparam int SHIFT = DW - 1;
   localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (DW - 1)) - 1);
   localparam logic signed [SW-1:0] MINV = -SW'(1 <<< (DW - 1));

   logic signed [DW-1:0] i_q, q_q;
   mix_ctl_t             ctl_q;
   logic signed [PW-1:0] prod_i, prod_q;
   logic signed [SW-1:0] sum, rnd, rnd_add;

   if (ROUND_HALF) begin : g_round
      assign rnd_add = SW'(1 <<< (DW - 2));
   end else begin : g_trunc
      assign rnd_add = '0;
   end

   always_comb begin
      prod_i = PW'(i_q) * PW'(cos_in);
      prod_q = PW'(q_q) * PW'(sin_in);
      if (ctl_q.sign == MIX_ADD)
         sum = SW'(prod_i) + SW'(prod_q);
      else
         sum = SW'(prod_i) - SW'(prod_q);
      rnd = (sum + rnd_add) >>> SHIFT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         i_q   <= '0;
         q_q   <= '0;
         ctl_q <= '{tone: 1'b0, sign: MIX_SUB};
         dout  <= '0;
      end else begin
         i_q   <= i_in;
         q_q   <= q_in;
         ctl_q <= '{tone: tone, sign: inv ? MIX_ADD : MIX_SUB};
         if (ctl_q.tone)
            dout <= cos_in;
         else if (rnd > MAXV)
            dout <= MAXV[DW-1:0];
         else if (rnd < MINV)
            dout <= MINV[DW-1:0];
         else
            dout <= rnd[DW-1:0];
      end
   end

   // R6: silent data with the tone path off yields a silent output
   a_r6_zero_in: assert property (@(posedge clk) disable iff (rst)
      (i_q == 0 && q_q == 0 && !ctl_q.tone) |=> (dout == 0));
endmodule

// File: rtl/nco_qmod.sv
module nco_qmod #(
   parameter int ACC_W = 32,
   parameter int LUT_W = 8,
   parameter int DW    = 12,
   parameter int NPROF = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [1:0]           wr_prof,
   input  logic [1:0]           wr_lane,
   input  logic [7:0]           wr_byte,
   input  logic                 freq_update,
   input  logic [1:0]           prof_sel,
   input  logic                 spec_inv,
   input  logic                 tone_mode,
   input  logic signed [DW-1:0] i_in,
   input  logic signed [DW-1:0] q_in,
   output logic signed [DW-1:0] dout
);
   if (NPROF != 4 || ACC_W != 32) begin : g_bad_top
      $error("the top port list fixes NPROF at 4 and ACC_W at 32");
   end

   logic [ACC_W-1:0]     ftw;
   logic signed [DW-1:0] sin_s, cos_s;

   nco_profile_bank #(.ACC_W(ACC_W), .NPROF(NPROF)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_prof(wr_prof),
      .wr_lane(wr_lane),
      .wr_byte(wr_byte),
      .upd    (freq_update),
      .sel    (prof_sel),
      .ftw    (ftw)
   );

   nco_phase_lut #(.ACC_W(ACC_W), .LUT_W(LUT_W), .DW(DW)) u_lut (
      .clk  (clk),
      .rst  (rst),
      .ftw  (ftw),
      .sin_q(sin_s),
      .cos_q(cos_s)
   );

   nco_mixer #(.DW(DW), .ROUND_HALF(1'b1)) u_mix (
      .clk   (clk),
      .rst   (rst),
      .i_in  (i_in),
      .q_in  (q_in),
      .inv   (spec_inv),
      .tone  (tone_mode),
      .sin_in(sin_s),
      .cos_in(cos_s),
      .dout  (dout)
   );
endmodule

// File: tb/tb_nco_qmod.sv
module tb_nco_qmod;
   localparam real PI = 3.14159265358979323846;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_prof = '0, wr_lane = '0, prof_sel = '0;
   logic [7:0]        wr_byte = '0;
   logic              freq_update = 1'b0, spec_inv = 1'b0, tone_mode = 1'b0;
   logic signed [11:0] i_in = '0, q_in = '0;
   logic signed [11:0] dout;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   nco_qmod dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prof(wr_prof), .wr_lane(wr_lane),
      .wr_byte(wr_byte), .freq_update(freq_update), .prof_sel(prof_sel),
      .spec_inv(spec_inv), .tone_mode(tone_mode), .i_in(i_in), .q_in(q_in),
      .dout(dout)
   );

   // ---------------- reference model built from the requirements ----------------
   function automatic int sinv(int p);
      real x;
      x = 2047.0 * $sin(2.0 * PI * (real'(p % 256) + 0.5) / 256.0);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int mixv(int i, int q, int c, int s, bit inv);
      longint y, r;
      y = inv ? (longint'(i) * c + longint'(q) * s) : (longint'(i) * c - longint'(q) * s);
      r = (y + 1024) >>> 11;
      if (r > 2047)  r = 2047;
      if (r < -2048) r = -2048;
      return int'(r);
   endfunction

   logic [31:0] m_stg [4];
   logic [31:0] m_act [4];
   logic [31:0] m_acc;
   int m_sin, m_cos, m_i, m_q, m_dout;
   bit m_inv, m_tone;

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < 4; k++) begin
            m_stg[k] <= '0;
            m_act[k] <= '0;
         end
         m_acc <= '0; m_sin <= 0; m_cos <= 0; m_i <= 0; m_q <= 0;
         m_inv <= 0; m_tone <= 0; m_dout <= 0;
      end else begin
         m_acc <= m_acc + m_act[prof_sel];
         if (wr_en) m_stg[wr_prof][{wr_lane, 3'b000} +: 8] <= wr_byte;
         if (freq_update)
            for (int k = 0; k < 4; k++) m_act[k] <= m_stg[k];
         m_sin  <= sinv(int'(m_acc[31:24]));
         m_cos  <= sinv(int'(m_acc[31:24]) + 64);
         m_i    <= int'(i_in);
         m_q    <= int'(q_in);
         m_inv  <= spec_inv;
         m_tone <= tone_mode;
         m_dout <= m_tone ? m_cos : mixv(m_i, m_q, m_cos, m_sin, m_inv);
      end
   end

   // ---------------- helpers ----------------
   task automatic step();
      @(posedge clk);
      #2;
      checks++;
      if (int'(dout) !== m_dout) begin
         errors++;
         $display("FAIL %s dout actual=%0d expected=%0d", cur_req, dout, m_dout);
      end
      @(negedge clk);
   endtask

   task automatic expect_val(string req, int exp);
      checks++;
      if (int'(dout) !== exp) begin
         errors++;
         $display("FAIL %s directed actual=%0d expected=%0d", req, dout, exp);
      end
   endtask

   task automatic put_word(int p, logic [31:0] w);
      for (int l = 0; l < 4; l++) begin
         wr_en = 1'b1; wr_prof = 2'(p); wr_lane = 2'(l); wr_byte = w[8*l +: 8];
         step();
      end
      wr_en = 1'b0;
   endtask

   task automatic pulse_update();
      freq_update = 1'b1;
      step();
      freq_update = 1'b0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd20417);
      @(negedge clk);
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state, silent output
      cur_req = "R1";
      expect_val("R1", 0);
      repeat (4) step();
      expect_val("R1", 0);

      // R2: staged bytes do not move the phase; tone shows cos(p=0)=2047
      cur_req = "R2";
      tone_mode = 1'b1;
      put_word(0, 32'h0100_0000);
      repeat (3) step();
      expect_val("R2", 2047);

      // R3: update applies the staged word; carrier then steps one table entry per clock
      cur_req = "R3";
      pulse_update();
      repeat (4) step();

      // R5: table values over several full turns in tone mode
      cur_req = "R5";
      repeat (600) step();

      // R3: write on the same edge as an update lands only in staging
      cur_req = "R3";
      wr_en = 1'b1; wr_prof = 2'd0; wr_lane = 2'd3; wr_byte = 8'h03; freq_update = 1'b1;
      step();
      wr_en = 1'b0; freq_update = 1'b0;
      repeat (40) step();
      pulse_update();
      repeat (40) step();

      // R4: four profiles, random switching, phase continuity
      cur_req = "R4";
      for (int p = 0; p < 4; p++) put_word(p, $urandom());
      pulse_update();
      for (int n = 0; n < 300; n++) begin
         prof_sel = 2'($urandom_range(0, 3));
         step();
      end

      // R6: subtraction mixing with random data
      cur_req = "R6";
      tone_mode = 1'b0; spec_inv = 1'b0;
      for (int n = 0; n < 400; n++) begin
         i_in = 12'($urandom()); q_in = 12'($urandom());
         if (n % 37 == 0) prof_sel = 2'($urandom_range(0, 3));
         step();
      end

      // R7: addition mixing with random data
      cur_req = "R7";
      spec_inv = 1'b1;
      for (int n = 0; n < 400; n++) begin
         i_in = 12'($urandom()); q_in = 12'($urandom());
         step();
      end

      // R8: full-scale data drives both saturation limits
      cur_req = "R8";
      for (int n = 0; n < 400; n++) begin
         i_in = ($urandom_range(0, 1) != 0) ? 12'sd2047 : -12'sd2048;
         q_in = ($urandom_range(0, 1) != 0) ? 12'sd2047 : -12'sd2048;
         spec_inv = 1'($urandom_range(0, 1));
         step();
      end

      // R9: tone mode ignores data and inversion
      cur_req = "R9";
      tone_mode = 1'b1;
      for (int n = 0; n < 200; n++) begin
         i_in = 12'($urandom()); q_in = 12'($urandom());
         spec_inv = 1'($urandom_range(0, 1));
         step();
      end

      // R10: single-cycle data pulses, random tone and updates mixed in
      cur_req = "R10";
      for (int n = 0; n < 400; n++) begin
         tone_mode = (n % 5 == 0);
         i_in = (n % 3 == 0) ? 12'($urandom()) : 12'sd0;
         q_in = (n % 4 == 0) ? 12'($urandom()) : 12'sd0;
         wr_en = 1'($urandom_range(0, 1));
         wr_prof = 2'($urandom()); wr_lane = 2'($urandom()); wr_byte = 8'($urandom());
         freq_update = ($urandom_range(0, 15) == 0);
         step();
      end
      wr_en = 1'b0; freq_update = 1'b0; i_in = '0; q_in = '0; tone_mode = 1'b0;
      repeat (3) step();
      expect_val("R10", 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule